// File: doc/BRIEF.md
# Byte Shuffle Unit

The byte shuffle unit is the 64-bit integer datapath slice that moves, isolates and clears bytes inside a quadword. Together with an aligned load or store, these operations let software handle unaligned data. A 7-bit function code selects the operation. Operand A is the data word. Operand B is either a register value or a literal, and the unit only looks at its low bits: the low six bits give a shift count, the low three bits give a byte offset, and the low eight bits give a byte-select mask.

The unit offers three kinds of operation. The first is plain shifts. The second is a family of mask, extract and insert operations on byte, word, longword and quadword fields, each in a "low" and a "high" form. The third is two byte-zeroing operations. The arithmetic is purely combinational. A parameter places an output register behind it, and that register is present by default, so a result appears one clock after its operands. Function codes outside the supported set give a zero result and raise an illegal-function flag.

Top module: `byte_shuffle_unit`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the registered result and the illegal flag are cleared to zero. With the default output register, each result and flag appear exactly one clock edge after their inputs are sampled.
- R2: Code 0x39 shifts A left logically, 0x34 shifts A right logically, and 0x3c shifts A right arithmetically, all by B[5:0] bit positions. B bits above bit 5 have no effect.
- R3: Codes 0x02, 0x12, 0x22 and 0x32 clear in A the bytes k with off ≤ k < off+n, where off = B[2:0] and n is 1, 2, 4 or 8 respectively. Bytes that would lie above byte 7 are dropped.
- R4: Codes 0x52, 0x62 and 0x72 (n = 2, 4, 8) clear in A the bytes k with k < off+n−8. An offset of zero therefore returns A unchanged.
- R5: Codes 0x06, 0x16, 0x26 and 0x36 (n = 1, 2, 4, 8) shift A right by 8×off bits and keep the low n bytes. All other result bytes are zero.
- R6: Codes 0x5a, 0x6a and 0x7a (n = 2, 4, 8) shift A left by (64 − 8×off) mod 64 bits and keep the low n bytes. An offset of zero therefore gives the low n bytes of A with no shift.
- R7: Codes 0x0b, 0x1b, 0x2b and 0x3b (n = 1, 2, 4, 8) take the low n bytes of A and shift them left by 8×off bits. Bits shifted past bit 63 are lost.
- R8: Codes 0x57, 0x67 and 0x77 (n = 2, 4, 8) take the low n bytes of A and shift them right by 64 − 8×off bits. An offset of zero gives a zero result.
- R9: Code 0x30 zeroes byte i of A wherever B[i] is 1. Code 0x31 zeroes byte i of A wherever B[i] is 0. Here i runs from 0 to 7 and byte i is bits 8i+7..8i.
- R10: Any code other than those listed in R2 to R9 gives a zero result with the illegal flag set. Every listed code gives the illegal flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| func_i | input | 7 | Function code |
| opa_i | input | 64 | Data operand A |
| opb_i | input | 64 | Operand B (register or literal): shift count, byte offset or byte-select mask |
| result_o | output | 64 | Result |
| illegal_o | output | 1 | High when func_i was not a supported code |

## Verification
With the default output register, each result and its illegal flag are due one rising edge after the operands and code are applied. There are no multi-cycle operations and no pending state. The bench applies a new operation shortly after each rising edge and compares both outputs shortly after the following edge, against a byte-lane model evaluated for the operation applied one edge earlier. This keeps every comparison aligned to the single-cycle latency. Reset is checked across two edges with live, non-zero operands on the inputs.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [3:0] {
    OP_SLL, OP_SRL, OP_SRA,
    OP_MSKL, OP_MSKH,
    OP_EXTL, OP_EXTH,
    OP_INSL, OP_INSH,
    OP_ZAP, OP_ZAPNOT,
    OP_NONE
  } bsu_op_e;

  // size: 0 byte, 1 word, 2 longword, 3 quadword
  typedef struct packed {
    bsu_op_e    op;
    logic [1:0] size;
  } bsu_dec_t;

  localparam logic [6:0] FC_SLL    = 7'h39;
  localparam logic [6:0] FC_SRL    = 7'h34;
  localparam logic [6:0] FC_SRA    = 7'h3c;
  localparam logic [6:0] FC_ZAP    = 7'h30;
  localparam logic [6:0] FC_ZAPNOT = 7'h31;

endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
  import bsu_pkg::*;
(
  input  logic [6:0] func,
  output bsu_dec_t   dec
);

  always_comb begin
    dec.size = func[5:4];
    case (func)
      FC_SLL:                        dec.op = OP_SLL;
      FC_SRL:                        dec.op = OP_SRL;
      FC_SRA:                        dec.op = OP_SRA;
      FC_ZAP:                        dec.op = OP_ZAP;
      FC_ZAPNOT:                     dec.op = OP_ZAPNOT;
      7'h02, 7'h12, 7'h22, 7'h32:    dec.op = OP_MSKL;
      7'h52, 7'h62, 7'h72:           dec.op = OP_MSKH;
      7'h06, 7'h16, 7'h26, 7'h36:    dec.op = OP_EXTL;
      7'h5a, 7'h6a, 7'h7a:           dec.op = OP_EXTH;
      7'h0b, 7'h1b, 7'h2b, 7'h3b:    dec.op = OP_INSL;
      7'h57, 7'h67, 7'h77:           dec.op = OP_INSH;
      default:                       dec.op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  bsu_dec_t          dec,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              bad
);

  localparam int LANES = DATA_W / 8;
  localparam int OFFW  = $clog2(LANES);
  localparam int SHW   = $clog2(DATA_W);

  logic [OFFW-1:0]   off;
  logic [SHW-1:0]    amt;
  logic [SHW-1:0]    bsh;
  logic [SHW:0]      inv;
  logic [SHW-1:0]    fbits;
  logic [DATA_W-1:0] fmask;
  logic [DATA_W-1:0] zap_y;
  logic [DATA_W-1:0] keep_y;
  logic [DATA_W-1:0] sra_y;
  logic              unused_b;

  assign off      = b[OFFW-1:0];
  assign amt      = b[SHW-1:0];
  assign bsh      = {off, 3'b000};
  assign inv      = (SHW+1)'(DATA_W) - {1'b0, bsh};
  assign unused_b = ^b[DATA_W-1:LANES];

  // field of ones covering the low 1, 2, 4 or all lanes
  assign fbits = SHW'(8) << dec.size;
  assign fmask = (dec.size == 2'd3) ? '1
               : ((DATA_W'(1) << fbits) - DATA_W'(1));

  assign sra_y = DATA_W'($signed(a) >>> amt);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign zap_y[8*g +: 8]  = b[g] ? 8'h00 : a[8*g +: 8];
    assign keep_y[8*g +: 8] = b[g] ? a[8*g +: 8] : 8'h00;
  end

  always_comb begin
    bad = 1'b0;
    case (dec.op)
      OP_SLL:    y = a << amt;
      OP_SRL:    y = a >> amt;
      OP_SRA:    y = sra_y;
      OP_MSKL:   y = a & ~(fmask << bsh);
      OP_MSKH:   y = (off == '0) ? a : (a & ~(fmask >> inv));
      OP_EXTL:   y = (a >> bsh) & fmask;
      OP_EXTH:   y = (a << inv[SHW-1:0]) & fmask;
      OP_INSL:   y = (a & fmask) << bsh;
      OP_INSH:   y = (off == '0) ? '0 : ((a & fmask) >> inv);
      OP_ZAP:    y = zap_y;
      OP_ZAPNOT: y = keep_y;
      default: begin
        y   = '0;
        bad = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
  import bsu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        func_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);

  bsu_dec_t          dec;
  logic [DATA_W-1:0] comb_y;
  logic              comb_bad;

  bsu_decode i_decode (
    .func (func_i),
    .dec  (dec)
  );

  bsu_datapath #(.DATA_W(DATA_W)) i_datapath (
    .dec (dec),
    .a   (opa_i),
    .b   (opb_i),
    .y   (comb_y),
    .bad (comb_bad)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        result_o  <= '0;
        illegal_o <= 1'b0;
      end else begin
        result_o  <= comb_y;
        illegal_o <= comb_bad;
      end
    end
  end else begin : g_comb
    assign result_o  = comb_y;
    assign illegal_o = comb_bad;
  end

endmodule

// File: rtl/bsu_chk.sv
module bsu_chk #(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [6:0]        func_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o
);

  localparam int LANES = DATA_W / 8;

  if (REG_OUT) begin : g_seq
    // R1
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (result_o == '0 && !illegal_o));

    // R10
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
      illegal_o |-> (result_o == '0));

    // R9
    zap_all_chk: assert property (@(posedge clk) disable iff (rst)
      (func_i == 7'h30 && opb_i[LANES-1:0] == '1) |=> (result_o == '0));

    // R8
    insh_off0_chk: assert property (@(posedge clk) disable iff (rst)
      ((func_i == 7'h57 || func_i == 7'h67 || func_i == 7'h77) && opb_i[2:0] == 3'd0)
      |=> (result_o == '0));

    // R4
    mskh_off0_chk: assert property (@(posedge clk) disable iff (rst)
      ((func_i == 7'h52 || func_i == 7'h62 || func_i == 7'h72) && opb_i[2:0] == 3'd0)
      |=> (result_o == $past(opa_i)));

    // R5
    extbl_width_chk: assert property (@(posedge clk) disable iff (rst)
      (func_i == 7'h06) |=> (result_o[DATA_W-1:8] == '0 && !illegal_o));

    // R2
    sll_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (func_i == 7'h39 && opb_i[5:0] == 6'd0) |=> (result_o == $past(opa_i)));
  end

endmodule

bind byte_shuffle_unit bsu_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) i_bsu_chk (
  .clk       (clk),
  .rst       (rst),
  .func_i    (func_i),
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .result_o  (result_o),
  .illegal_o (illegal_o)
);

// File: tb/test_byte_shuffle_unit.sv
`timescale 1ns/1ps
module test_byte_shuffle_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  func_i = '0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic [63:0] result_o;
  logic        illegal_o;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  byte_shuffle_unit #(.DATA_W(64), .REG_OUT(1'b1)) i_byte_shuffle_unit (
    .clk       (clk),
    .rst       (rst),
    .func_i    (func_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .result_o  (result_o),
    .illegal_o (illegal_o)
  );

  logic [6:0] legal_codes [27] = '{
    7'h39, 7'h34, 7'h3c,
    7'h02, 7'h12, 7'h22, 7'h32,
    7'h52, 7'h62, 7'h72,
    7'h06, 7'h16, 7'h26, 7'h36,
    7'h5a, 7'h6a, 7'h7a,
    7'h0b, 7'h1b, 7'h2b, 7'h3b,
    7'h57, 7'h67, 7'h77,
    7'h30, 7'h31, 7'h00
  };

  function automatic string req_of(input logic [6:0] f);
    case (f)
      7'h39, 7'h34, 7'h3c:         return "R2";
      7'h02, 7'h12, 7'h22, 7'h32:  return "R3";
      7'h52, 7'h62, 7'h72:         return "R4";
      7'h06, 7'h16, 7'h26, 7'h36:  return "R5";
      7'h5a, 7'h6a, 7'h7a:         return "R6";
      7'h0b, 7'h1b, 7'h2b, 7'h3b:  return "R7";
      7'h57, 7'h67, 7'h77:         return "R8";
      7'h30, 7'h31:                return "R9";
      default:                     return "R10";
    endcase
  endfunction

  // Byte-lane reference: returns {illegal, result}
  function automatic logic [64:0] ref_calc(input logic [6:0] f,
                                           input logic [63:0] a,
                                           input logic [63:0] b);
    logic [63:0] r = '0;
    int off = int'(b[2:0]);
    int sh  = int'(b[5:0]);
    int n   = 1 << int'(f[5:4]);
    int s;
    case (f)
      7'h39: r = a << sh;
      7'h34: r = a >> sh;
      7'h3c: for (int i = 0; i < 64; i++) r[i] = (i + sh <= 63) ? a[i+sh] : a[63];
      7'h02, 7'h12, 7'h22, 7'h32:
        for (int k = 0; k < 8; k++)
          r[8*k +: 8] = (k >= off && k < off + n) ? 8'h00 : a[8*k +: 8];
      7'h52, 7'h62, 7'h72:
        for (int k = 0; k < 8; k++)
          r[8*k +: 8] = (k < off + n - 8) ? 8'h00 : a[8*k +: 8];
      7'h06, 7'h16, 7'h26, 7'h36:
        for (int k = 0; k < 8; k++)
          r[8*k +: 8] = (k < n && k + off < 8) ? a[8*(k+off) +: 8] : 8'h00;
      7'h5a, 7'h6a, 7'h7a: begin
        s = (8 - off) % 8;
        for (int k = 0; k < 8; k++)
          r[8*k +: 8] = (k < n && k >= s) ? a[8*(k-s) +: 8] : 8'h00;
      end
      7'h0b, 7'h1b, 7'h2b, 7'h3b:
        for (int k = 0; k < 8; k++)
          r[8*k +: 8] = (k - off >= 0 && k - off < n) ? a[8*(k-off) +: 8] : 8'h00;
      7'h57, 7'h67, 7'h77:
        for (int k = 0; k < 8; k++)
          r[8*k +: 8] = (k + 8 - off < n) ? a[8*(k+8-off) +: 8] : 8'h00;
      7'h30:
        for (int k = 0; k < 8; k++) r[8*k +: 8] = b[k] ? 8'h00 : a[8*k +: 8];
      7'h31:
        for (int k = 0; k < 8; k++) r[8*k +: 8] = b[k] ? a[8*k +: 8] : 8'h00;
      default: return {1'b1, 64'h0};
    endcase
    return {1'b0, r};
  endfunction

  task automatic check(input string req, input logic [64:0] exp);
    checks++;
    if ({illegal_o, result_o} !== exp) begin
      failures++;
      $display("FAIL %s: got ill=%0b res=%h, expected ill=%0b res=%h",
               req, illegal_o, result_o, exp[64], exp[63:0]);
    end
  endtask

  // drive just after an edge, compare just after the next one
  task automatic run(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b);
    logic [64:0] exp;
    func_i = f;
    opa_i  = a;
    opb_i  = b;
    exp    = ref_calc(f, a, b);
    @(posedge clk);
    #1;
    check(req_of(f), exp);
  endtask

  initial begin
    // R1: reset clears outputs even with live operands
    func_i = 7'h31;
    opa_i  = 64'hFEDC_BA98_7654_3210;
    opb_i  = 64'hFF;
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R1", 65'h0);
    func_i = 7'h7f;
    @(posedge clk);
    #1;
    check("R1", 65'h0);
    rst = 1'b0;

    // R1: one-edge latency, back-to-back results
    run(7'h39, 64'h1, 64'h4);
    run(7'h34, 64'h80, 64'h3);

    // every legal code at every offset, upper B bits set
    for (int c = 0; c < 27; c++)
      for (int o = 0; o < 8; o++)
        run(legal_codes[c], 64'h0123_4567_89AB_CDEF ^ {8{8'(o * 17)}},
            {56'hA5A5_5A5A_C3C3_3C, 5'(c + o), 3'(o)});

    // R2: shift boundaries
    run(7'h3c, 64'h8000_0000_0000_0000, 64'd63);
    run(7'h3c, 64'h7FFF_FFFF_FFFF_FFFF, 64'd63);
    run(7'h34, 64'h8000_0000_0000_0000, 64'hFFFF_FFC0);
    run(7'h39, 64'hFFFF_FFFF_FFFF_FFFF, 64'd63);

    // R9: all-set and all-clear select masks
    run(7'h30, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF);
    run(7'h31, 64'hFFFF_FFFF_FFFF_FFFF, 64'h00);
    run(7'h31, 64'h1122_3344_5566_7788, 64'hFFFF_FF5A);

    // R10: codes neighbouring legal ones
    run(7'h7f, 64'h1234, 64'h5);
    run(7'h01, 64'h1234, 64'h5);
    run(7'h42, 64'hFFFF, 64'h0);

    // random operations across the full code space
    for (int i = 0; i < 600; i++)
      run(7'($urandom), {$urandom, $urandom}, {$urandom, $urandom});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule